// File: doc/BRIEF.md
# Miss Latency Breakdown Profiler

This block collects latency statistics for completed memory requests. Each completion brings a total latency, a flag that says whether the request was served by a miss or a hit, a responder code, and five timestamps: issue, initial request, forwarded request, first response and completion. The total latency is binned into an overall histogram, then into a hit or a miss histogram, and then into a per-responder histogram when the responder code is valid.

For a miss with a valid responder, the block splits the request into four stage delays, one between each pair of neighbouring timestamps. Each delay is binned into a histogram kept for that responder and stage. The split is accepted only when the timestamps never decrease. When they do decrease, a per-responder counter of incomplete timestamp sets is bumped and no stage histogram moves.

Every histogram has `NBKT` buckets, each `2**BKT_SHIFT` units wide. Software-side logic reads the counters through a word-addressed read port and clears them all with a statistics clear input.

Top module: `miss_lat_profiler`

## Requirements
- R1: Every cycle with `cmp_valid_i` high adds one to bucket `min(cmp_lat_i >> BKT_SHIFT, NBKT-1)` of the overall histogram (histogram 0).
- R2: The same bucket of the hit histogram (histogram 1) is incremented when `cmp_miss_i` is 0, and that of the miss histogram (histogram 2) when it is 1. The other one is unchanged.
- R3: The per-responder histogram `3+r` takes the total latency only when `cmp_resp_i == r` and `r < N_RESP`. A code of `N_RESP` or above means no responder, and no per-responder histogram, stage histogram or incomplete counter changes.
- R4: A miss with valid responder `r` and `issue <= init <= fwd <= first <= done` (unsigned) bins the delays `init-issue`, `fwd-init`, `first-fwd` and `done-first`. Stage `s` (0 to 3, in that order) goes into histogram `3+N_RESP+4*r+s`.
- R5: A miss with valid responder `r` whose timestamps decrease anywhere along that chain increments incomplete counter `r` and changes no stage histogram. Equal neighbouring timestamps are not a decrease.
- R6: A hit never changes a stage histogram or an incomplete counter, whatever its timestamps.
- R7: Values whose bucket index `value >> BKT_SHIFT` is `NBKT` or more are counted in bucket `NBKT-1`.
- R8: Every bucket and incomplete counter stops at `2**CNT_W-1` and does not wrap.
- R9: A high `stat_clr_i` zeroes every bucket and incomplete counter at the next clock edge. A completion presented in the same cycle is discarded.
- R10: Reading address `h*NBKT+b` returns bucket `b` of histogram `h`, and address `NUM_HIST*NBKT+r` returns incomplete counter `r`, where `NUM_HIST = 3+5*N_RESP`. Data appears one clock after the address is presented. Addresses beyond the last word return 0.
- R11: After reset every readable word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_clr_i | input | 1 | Clear all statistics |
| cmp_valid_i | input | 1 | Completion present this cycle |
| cmp_miss_i | input | 1 | 1 = served by a miss, 0 = hit |
| cmp_resp_i | input | RESP_W = clog2(N_RESP+1) | Responder code, N_RESP or above = none |
| cmp_lat_i | input | LAT_W | Total latency |
| ts_issue_i | input | TS_W | Issue timestamp |
| ts_init_i | input | TS_W | Initial request timestamp |
| ts_fwd_i | input | TS_W | Forwarded request timestamp |
| ts_first_i | input | TS_W | First response timestamp |
| ts_done_i | input | TS_W | Completion timestamp |
| rd_addr_i | input | ADDR_W = clog2(NUM_HIST*NBKT+N_RESP+1) | Read word address |
| rd_data_o | output | CNT_W | Read data, one cycle after the address |

## Verification
A wrong bucket select, a misrouted histogram increment or a faulty order check leaves a counter one count away from the arithmetic model. The error shows on the read port as soon as that word is swept, one cycle after its address is presented. A counter that wraps instead of saturating shows as a small value where the maximum is expected. A clear that loses to a concurrent completion shows as a single stray count in the next sweep. Each sweep reads every word, so any single misplaced count is seen in the sweep that follows the stimulus that caused it.

// File: rtl/lat_prof_pkg.sv
package lat_prof_pkg;
  localparam int unsigned NUM_STAGES = 4;

  // bucket index with the top bucket catching everything beyond it
  function automatic int unsigned bkt_of(input logic [31:0] v,
                                         input int unsigned shift,
                                         input int unsigned nbkt);
    logic [31:0] q;
    q = v >> shift;
    if (q >= nbkt) return nbkt - 1;
    return int'(q);
  endfunction
endpackage

// File: rtl/lat_prof_sat_cnt.sv
module lat_prof_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o && !clr_i) |=> &cnt_o);
  assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  assert_single_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/lat_prof_hist.sv
module lat_prof_hist #(
  parameter int unsigned NBKT      = 10,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned VAL_W     = 16,
  parameter int unsigned BKT_SHIFT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  input  logic [VAL_W-1:0]      val_i,
  output logic [NBKT*CNT_W-1:0] cnt_o
);
  int unsigned bsel;
  logic [NBKT-1:0] bkt_inc;

  always_comb bsel = lat_prof_pkg::bkt_of(32'(val_i), BKT_SHIFT, NBKT);

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    assign bkt_inc[b] = inc_i && (bsel == b);
    lat_prof_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (bkt_inc[b]),
      .cnt_o (cnt_o[b*CNT_W +: CNT_W])
    );
  end

  assert_one_bucket_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bkt_inc) && (inc_i == |bkt_inc));
endmodule

// File: rtl/lat_prof_stage.sv
module lat_prof_stage #(
  parameter int unsigned TS_W = 32
) (
  input  logic                                         [TS_W-1:0] t_issue_i,
  input  logic                                         [TS_W-1:0] t_init_i,
  input  logic                                         [TS_W-1:0] t_fwd_i,
  input  logic                                         [TS_W-1:0] t_first_i,
  input  logic                                         [TS_W-1:0] t_done_i,
  output logic                                                    mono_o,
  output logic [lat_prof_pkg::NUM_STAGES-1:0][TS_W-1:0]           dly_o
);
  always_comb begin
    mono_o   = (t_issue_i <= t_init_i) && (t_init_i <= t_fwd_i) &&
               (t_fwd_i <= t_first_i) && (t_first_i <= t_done_i);
    dly_o[0] = t_init_i  - t_issue_i;
    dly_o[1] = t_fwd_i   - t_init_i;
    dly_o[2] = t_first_i - t_fwd_i;
    dly_o[3] = t_done_i  - t_first_i;
  end

  always_comb begin
    if (mono_o === 1'b1)
      assert_delay_sum_R4: assert (TS_W'(dly_o[0] + dly_o[1] + dly_o[2] + dly_o[3])
                                   == TS_W'(t_done_i - t_issue_i));
  end
endmodule

// File: rtl/miss_lat_profiler.sv
module miss_lat_profiler #(
  parameter int unsigned N_RESP    = 4,
  parameter int unsigned NBKT      = 10,
  parameter int unsigned BKT_SHIFT = 3,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LAT_W     = 16,
  parameter int unsigned TS_W      = 32,
  localparam int unsigned RESP_W    = $clog2(N_RESP + 1),
  localparam int unsigned NUM_HIST  = 3 + 5 * N_RESP,
  localparam int unsigned NUM_WORDS = NUM_HIST * NBKT + N_RESP,
  localparam int unsigned ADDR_W    = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_clr_i,
  input  logic              cmp_valid_i,
  input  logic              cmp_miss_i,
  input  logic [RESP_W-1:0] cmp_resp_i,
  input  logic [LAT_W-1:0]  cmp_lat_i,
  input  logic [TS_W-1:0]   ts_issue_i,
  input  logic [TS_W-1:0]   ts_init_i,
  input  logic [TS_W-1:0]   ts_fwd_i,
  input  logic [TS_W-1:0]   ts_first_i,
  input  logic [TS_W-1:0]   ts_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  localparam int unsigned NST      = lat_prof_pkg::NUM_STAGES;
  localparam int unsigned RSP_BASE = 3;
  localparam int unsigned STG_BASE = 3 + N_RESP;
  localparam int unsigned INC_BASE = NUM_HIST * NBKT;

  logic                       mono;
  logic [NST-1:0][TS_W-1:0]   dly;
  logic [NBKT*CNT_W-1:0]      hcnt [NUM_HIST];
  logic [CNT_W-1:0]           icnt [N_RESP];
  logic [CNT_W-1:0]           words [NUM_WORDS];
  logic [N_RESP-1:0]          rsp_hit;

  lat_prof_stage #(.TS_W(TS_W)) u_stage (
    .t_issue_i(ts_issue_i),
    .t_init_i (ts_init_i),
    .t_fwd_i  (ts_fwd_i),
    .t_first_i(ts_first_i),
    .t_done_i (ts_done_i),
    .mono_o   (mono),
    .dly_o    (dly)
  );

  // overall, hit, miss
  for (genvar k = 0; k < 3; k++) begin : g_top_hist
    logic inc;
    if (k == 0) begin : g_all
      assign inc = cmp_valid_i;
    end else if (k == 1) begin : g_hit
      assign inc = cmp_valid_i && !cmp_miss_i;
    end else begin : g_miss
      assign inc = cmp_valid_i && cmp_miss_i;
    end
    lat_prof_hist #(.NBKT(NBKT), .CNT_W(CNT_W), .VAL_W(LAT_W), .BKT_SHIFT(BKT_SHIFT)) u_hist (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (stat_clr_i),
      .inc_i (inc),
      .val_i (cmp_lat_i),
      .cnt_o (hcnt[k])
    );
  end

  for (genvar r = 0; r < N_RESP; r++) begin : g_rsp
    logic stg_inc;
    logic inc_inc;
    assign rsp_hit[r] = cmp_valid_i && (cmp_resp_i == RESP_W'(r));
    assign stg_inc    = rsp_hit[r] && cmp_miss_i && mono;
    assign inc_inc    = rsp_hit[r] && cmp_miss_i && !mono;

    lat_prof_hist #(.NBKT(NBKT), .CNT_W(CNT_W), .VAL_W(LAT_W), .BKT_SHIFT(BKT_SHIFT)) u_tot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (stat_clr_i),
      .inc_i (rsp_hit[r]),
      .val_i (cmp_lat_i),
      .cnt_o (hcnt[RSP_BASE + r])
    );

    for (genvar s = 0; s < NST; s++) begin : g_stg
      lat_prof_hist #(.NBKT(NBKT), .CNT_W(CNT_W), .VAL_W(TS_W), .BKT_SHIFT(BKT_SHIFT)) u_stg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (stat_clr_i),
        .inc_i (stg_inc),
        .val_i (dly[s]),
        .cnt_o (hcnt[STG_BASE + NST * r + s])
      );
    end

    lat_prof_sat_cnt #(.CNT_W(CNT_W)) u_incmp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (stat_clr_i),
      .inc_i (inc_inc),
      .cnt_o (icnt[r])
    );

    assign words[INC_BASE + r] = icnt[r];

    assert_incomplete_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((icnt[r] != $past(icnt[r])) && !$past(stat_clr_i)) |->
        $past(cmp_valid_i && cmp_miss_i && (cmp_resp_i == RESP_W'(r))));
  end

  for (genvar h = 0; h < NUM_HIST; h++) begin : g_map
    for (genvar b = 0; b < NBKT; b++) begin : g_w
      assign words[h * NBKT + b] = hcnt[h][b*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               rd_data_o <= '0;
    else if (rd_addr_i < ADDR_W'(NUM_WORDS))   rd_data_o <= words[rd_addr_i];
    else                                       rd_data_o <= '0;
  end

  assert_oob_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= ADDR_W'(NUM_WORDS)) |=> (rd_data_o == '0));
  assert_no_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_resp_i >= RESP_W'(N_RESP)) |-> (rsp_hit == '0));
endmodule

// File: tb/miss_lat_profiler_tb_top.sv
`timescale 1ns/1ps
module miss_lat_profiler_tb_top;
  localparam int NR = 2, NB = 10, SH = 2, CW = 6, LW = 8, TW = 8;
  localparam int NH = 3 + 5 * NR;
  localparam int NW = NH * NB + NR;
  localparam int AW = $clog2(NW + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0, miss = 1'b0;
  logic [1:0] resp = '0;
  logic [LW-1:0] lat = '0;
  logic [TW-1:0] t0 = '0, t1 = '0, t2 = '0, t3 = '0, t4 = '0;
  logic [AW-1:0] raddr = '0;
  logic [CW-1:0] rdata;

  int exp_w [NW];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  miss_lat_profiler #(.N_RESP(NR), .NBKT(NB), .BKT_SHIFT(SH), .CNT_W(CW),
                      .LAT_W(LW), .TS_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stat_clr_i(clr), .cmp_valid_i(vld),
    .cmp_miss_i(miss), .cmp_resp_i(resp), .cmp_lat_i(lat),
    .ts_issue_i(t0), .ts_init_i(t1), .ts_fwd_i(t2), .ts_first_i(t3),
    .ts_done_i(t4), .rd_addr_i(raddr), .rd_data_o(rdata));

  function automatic int bk(int v);
    return ((v >> SH) >= NB) ? NB - 1 : (v >> SH);
  endfunction

  function automatic string region(int a);
    if (a < NB)        return "R1";
    if (a < 3 * NB)    return "R2";
    if (a < 5 * NB)    return "R3";
    if (a < NH * NB)   return "R4";
    if (a < NW)        return "R5";
    return "R10";
  endfunction

  task automatic madd(int idx);
    if (exp_w[idx] < CMAX) exp_w[idx]++;
  endtask

  task automatic model_clear();
    for (int i = 0; i < NW; i++) exp_w[i] = 0;
  endtask

  task automatic complete(int l, int m, int r, int a0, int a1, int a2, int a3, int a4);
    int ts [5];
    bit mono;
    ts[0] = a0; ts[1] = a1; ts[2] = a2; ts[3] = a3; ts[4] = a4;
    @(negedge clk);
    vld = 1'b1; lat = LW'(l); miss = m[0]; resp = 2'(r);
    t0 = TW'(a0); t1 = TW'(a1); t2 = TW'(a2); t3 = TW'(a3); t4 = TW'(a4);
    madd(bk(l));
    madd((m != 0 ? 2 : 1) * NB + bk(l));
    if (r < NR) begin
      madd((3 + r) * NB + bk(l));
      if (m != 0) begin
        mono = 1'b1;
        for (int s = 0; s < 4; s++) if (ts[s] > ts[s+1]) mono = 1'b0;
        if (mono) for (int s = 0; s < 4; s++) madd((3 + NR + 4 * r + s) * NB + bk(ts[s+1] - ts[s]));
        else madd(NH * NB + r);
      end
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
  endtask

  task automatic check_word(int a, string tag);
    int e;
    @(negedge clk); raddr = AW'(a);
    @(negedge clk);
    e = (a < NW) ? exp_w[a] : 0;
    n_chk++;
    if (int'(rdata) != e) begin
      n_fail++;
      $display("FAIL %s/%s addr %0d: got %0d expected %0d", tag, region(a), a, rdata, e);
    end
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < NW; a++) check_word(a, tag);
    check_word(NW, tag);
    check_word((1 << AW) - 1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R11");

    // hits over all responder codes, out-of-order timestamps ignored
    for (int r = 0; r < 4; r++)
      for (int l = 0; l <= 60; l += 3) complete(l, 0, r, 50, 10, 5, 1, 0);
    sweep("R6");
    do_clear();

    // misses with monotonic timestamps
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 24; i++) begin
        int d [4];
        int a;
        for (int s = 0; s < 4; s++) d[s] = (i * (s + 3) * 5 + s * 7) % 50;
        a = i % 8;
        complete((i * 11) % 256, 1, r, a, a + d[0], a + d[0] + d[1],
                 a + d[0] + d[1] + d[2], a + d[0] + d[1] + d[2] + d[3]);
      end
    sweep("R4");
    do_clear();

    // one decreasing step at each stage, plus all-equal timestamps
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 4; s++) begin
        int ts [5];
        ts[0] = 5;
        for (int k = 1; k < 5; k++) ts[k] = (k == s + 1) ? ts[k-1] - 1 : ts[k-1] + 3;
        complete(20 + s, 1, r, ts[0], ts[1], ts[2], ts[3], ts[4]);
      end
      complete(7, 1, r, 9, 9, 9, 9, 9);
    end
    sweep("R5");
    do_clear();

    // top-bucket saturation and counter saturation
    for (int i = 0; i < CMAX + 8; i++) complete((i % 2) ? 255 : 40, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < CMAX + 3; i++) complete(3, 1, 1, 9, 8, 8, 8, 8);
    sweep("R7/R8");

    // clear wins over a completion in the same cycle
    @(negedge clk);
    clr = 1'b1; vld = 1'b1; miss = 1'b1; resp = 2'd0; lat = 8'd12;
    t0 = 8'd0; t1 = 8'd1; t2 = 8'd2; t3 = 8'd3; t4 = 8'd4;
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
    model_clear();
    sweep("R9");

    complete(33, 1, 1, 0, 4, 9, 17, 30);
    complete(5, 0, 0, 0, 0, 0, 0, 0);
    sweep("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule